// File: doc/BRIEF.md
# Packed-Lane High-Half Narrowing Adder

This block takes two 128-bit vector operands and splits each into wide lanes of 16, 32 or 64 bits. For every lane pair it forms the wrapped sum or difference at the full wide width. It can add a half-unit rounding constant. It then keeps only the upper half of the wide result. The narrowed lanes pack into a 64-bit vector of 8, 4 or 2 lanes. That vector is merged into a 128-bit destination in one of two ways. The low-half form writes the vector and zeroes the top. The high-half form writes the vector into the top and keeps the old low half.

The caller presents a decoded 32-bit instruction word, both operands and the current destination value, and strobes `inValid`. One clock later the unit returns the new destination value with `outValid`. An illegal width code raises the undefined flag. In that case the old destination comes back unchanged.

Top module: `hn_unit`

## Requirements
- R1: While `rstN` is low, `outValid` and `undefFlag` are 0 and `newDest` is all zeros.
- R2: `outValid` is 1 in the cycle after a clock edge that samples `inValid` high.
- R3: Width code 2'b11 in `instrWord[23:22]` sets `undefFlag` to 1. `newDest` then equals the `oldDest` that was sampled.
- R4: Width code k (0, 1 or 2) in `instrWord[23:22]` sets the narrow lane width to esize = 8<<k, with wide lanes of 2*esize. Narrow lane e is bits [2*esize-1:esize] of the wide result of source lanes e.
- R5: `instrWord[13]` = 1 selects opA lane minus opB lane, and 0 selects their sum. Both wrap modulo 2^(2*esize).
- R6: `instrWord[29]` = 1 adds 1<<(esize-1) to the wide result before the top half is taken. When the bit is 0, the top half is taken by truncation.
- R7: `instrWord[30]` = 0 puts the 64-bit narrow vector in `newDest[63:0]` and zeroes `newDest[127:64]`.
- R8: `instrWord[30]` = 1 puts the narrow vector in `newDest[127:64]`. `newDest[63:0]` then equals the sampled `oldDest[63:0]`.
- R9: After an edge that samples `inValid` low, `outValid` is 0 and `newDest` and `undefFlag` hold their values.
- R10: Bits of `instrWord` other than 30, 29, 23:22 and 13 do not change the result. This includes the register-number fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation request strobe |
| instrWord | input | 32 | Decoded instruction word |
| opA | input | 128 | First source vector |
| opB | input | 128 | Second source vector |
| oldDest | input | 128 | Current destination value |
| outValid | output | 1 | Result valid, one cycle after request |
| newDest | output | 128 | Updated destination value |
| undefFlag | output | 1 | Illegal width code seen |

## Verification
A wrong lane slice or a dropped carry between the two halves of a wide lane shows up as a wrong narrow byte or word in `newDest`. It appears in the first cycle after the request. The directed operands are chosen to reach those faults: all-ones plus one, zero minus one, and values one step below the rounding threshold. A faulty merge shows in the same cycle, either as non-zero upper bits or as a low half that differs from the sampled `oldDest`. A stuck valid or flag register shows at the next idle cycle.

// File: rtl/hn_pkg.sv
package hn_pkg;
  localparam int INSTR_W = 32;

  typedef struct packed {
    logic       load;
    logic       illegal;
    logic       upperPart;
    logic       doSub;
    logic       doRound;
    logic [1:0] sizeSel;
  } hnStrobes_t;
endpackage

// File: rtl/hn_ctrl.sv
module hn_ctrl
  import hn_pkg::*;
#(
  parameter int NUM_SIZES = 3,
  parameter int Q_BIT     = 30,
  parameter int RND_BIT   = 29,
  parameter int SIZE_LSB  = 22,
  parameter int SUB_BIT   = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  output hnStrobes_t         strobes,
  output logic               outValid,
  output logic               undefFlag
);
  logic [1:0] sizeField;

  assign sizeField = instrWord[SIZE_LSB +: 2];

  always_comb begin
    strobes.load      = inValid;
    strobes.sizeSel   = sizeField;
    strobes.illegal   = (int'(sizeField) >= NUM_SIZES);
    strobes.upperPart = instrWord[Q_BIT];
    strobes.doSub     = instrWord[SUB_BIT];
    strobes.doRound   = instrWord[RND_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      undefFlag <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) undefFlag <= strobes.illegal;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r9_idle_holds_flag: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(undefFlag)));
  a_r3_bad_size_flags: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[SIZE_LSB +: 2] == 2'b11) |=> undefFlag);
endmodule

// File: rtl/hn_datapath.sv
module hn_datapath
  import hn_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int MIN_ESIZE = 8,
  parameter int NUM_SIZES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  hnStrobes_t       strobes,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [VEC_W-1:0] oldDest,
  output logic [VEC_W-1:0] newDest
);
  localparam int HALF_W = VEC_W / 2;

  logic [NUM_SIZES-1:0][HALF_W-1:0] narrowBySize;
  logic [HALF_W-1:0]                narrowSel;
  logic [VEC_W-1:0]                 nextDest;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int ES    = MIN_ESIZE << s;
    localparam int WIDE  = 2 * ES;
    localparam int LANES = HALF_W / ES;
    localparam logic [WIDE-1:0] RND_CONST = WIDE'(1) << (ES - 1);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [WIDE-1:0] laneA, laneB, rawSum, rndAdd, laneSum;
      assign laneA   = opA[l*WIDE +: WIDE];
      assign laneB   = opB[l*WIDE +: WIDE];
      assign rawSum  = strobes.doSub ? (laneA - laneB) : (laneA + laneB);
      assign rndAdd  = strobes.doRound ? RND_CONST : '0;
      assign laneSum = rawSum + rndAdd;
      assign narrowBySize[s][l*ES +: ES] = laneSum[WIDE-1:ES];
    end
  end

  always_comb begin
    narrowSel = '0;
    for (int s = 0; s < NUM_SIZES; s++)
      if (int'(strobes.sizeSel) == s) narrowSel = narrowBySize[s];
  end

  always_comb begin
    if (strobes.illegal)
      nextDest = oldDest;
    else if (strobes.upperPart)
      nextDest = {narrowSel, oldDest[HALF_W-1:0]};
    else
      nextDest = {{HALF_W{1'b0}}, narrowSel};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             newDest <= '0;
    else if (strobes.load) newDest <= nextDest;
  end

  a_r7_low_write_clears_top: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.illegal && !strobes.upperPart) |=> (newDest[VEC_W-1:HALF_W] == '0));
  a_r8_high_write_keeps_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.illegal && strobes.upperPart) |=> (newDest[HALF_W-1:0] == $past(oldDest[HALF_W-1:0])));
  a_r3_illegal_keeps_dest: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.illegal) |=> (newDest == $past(oldDest)));
  a_r9_idle_holds_dest: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(newDest));
endmodule

// File: rtl/hn_unit.sv
module hn_unit
  import hn_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int MIN_ESIZE = 8,
  parameter int NUM_SIZES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [VEC_W-1:0]   opA,
  input  logic [VEC_W-1:0]   opB,
  input  logic [VEC_W-1:0]   oldDest,
  output logic               outValid,
  output logic [VEC_W-1:0]   newDest,
  output logic               undefFlag
);
  hnStrobes_t strobes;

  hn_ctrl #(.NUM_SIZES(NUM_SIZES)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .strobes(strobes), .outValid(outValid), .undefFlag(undefFlag)
  );

  hn_datapath #(.VEC_W(VEC_W), .MIN_ESIZE(MIN_ESIZE), .NUM_SIZES(NUM_SIZES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB),
    .oldDest(oldDest), .newDest(newDest)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!outValid && !undefFlag && newDest == '0));
endmodule

// File: tb/hn_unit_tb.sv
module hn_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [31:0]  instrWord = '0;
  logic [127:0] opA = '0, opB = '0, oldDest = '0;
  logic         outValid, undefFlag;
  logic [127:0] newDest;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hn_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .opA(opA), .opB(opB), .oldDest(oldDest),
    .outValid(outValid), .newDest(newDest), .undefFlag(undefFlag)
  );

  function automatic logic [127:0] refModel(logic [31:0] iw, logic [127:0] a, logic [127:0] b,
                                             logic [127:0] old);
    int sz;
    int es;
    logic [63:0] narrow;
    sz = int'(iw[23:22]);
    if (sz == 3) return old;
    es = 8 << sz;
    narrow = '0;
    for (int e = 0; e < 64 / es; e++) begin
      logic [63:0] mask, wa, wb, s;
      mask = (es == 32) ? '1 : ((64'd1 << (2 * es)) - 64'd1);
      wa = 64'(a >> (e * 2 * es)) & mask;
      wb = 64'(b >> (e * 2 * es)) & mask;
      s = iw[13] ? (wa - wb) : (wa + wb);
      if (iw[29]) s = s + (64'd1 << (es - 1));
      s = s & mask;
      narrow = narrow | (((s >> es) & ((64'd1 << es) - 64'd1)) << (e * es));
    end
    return iw[30] ? {narrow, old[63:0]} : {64'd0, narrow};
  endfunction

  function automatic logic [31:0] mkInstr(bit q, bit rnd, logic [1:0] sz, bit sub, logic [31:0] junk);
    logic [31:0] w;
    w = junk;
    w[30] = q;
    w[29] = rnd;
    w[23:22] = sz;
    w[13] = sub;
    return w;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(string req, logic [31:0] iw, logic [127:0] a, logic [127:0] b,
                       logic [127:0] old);
    logic [127:0] exp;
    @(negedge clk);
    inValid = 1'b1; instrWord = iw; opA = a; opB = b; oldDest = old;
    exp = refModel(iw, a, b, old);
    @(posedge clk);
    #1;
    check({req, " R2 valid"}, 128'(outValid), 128'd1);
    check({req, " undef"}, 128'(undefFlag), 128'(iw[23:22] == 2'b11));
    check(req, newDest, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    logic [31:0]  iwA;
    logic         heldFlag;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 outValid", 128'(outValid), 128'd0);
    check("R1 undef", 128'(undefFlag), 128'd0);
    check("R1 dest", newDest, 128'd0);
    @(negedge clk) rstN = 1'b1;

    // R5 carry wrap: lane0 FFFF+0001 -> top byte 00
    apply("R5 carry wrap", mkInstr(0, 0, 2'd0, 0, 32'h0), 128'h0000_FFFF, 128'h0000_0001, '1);
    check("R5 explicit byte", 128'(newDest[7:0]), 128'h00);
    // R5 borrow wrap: 0000-0001 -> FF
    apply("R5 borrow wrap", mkInstr(0, 0, 2'd0, 1, 32'h0), 128'h0, 128'h1, '0);
    check("R5 borrow byte", 128'(newDest[7:0]), 128'hFF);
    // R6 rounding crosses threshold: 7F80 + round -> 80
    apply("R6 round", mkInstr(0, 1, 2'd0, 0, 32'h0), 128'h7F80, 128'h0, '0);
    check("R6 round byte", 128'(newDest[7:0]), 128'h80);
    apply("R6 truncate", mkInstr(0, 0, 2'd0, 0, 32'h0), 128'h7F80, 128'h0, '0);
    check("R6 trunc byte", 128'(newDest[7:0]), 128'h7F);
    // R4 each size, R7/R8 each part, all add/sub/round combos
    for (int sz = 0; sz < 3; sz++)
      for (int q = 0; q < 2; q++)
        for (int m = 0; m < 4; m++)
          apply($sformatf("R4 R7 R8 sz=%0d q=%0d m=%0d", sz, q, m),
                mkInstr(q[0], m[1], sz[1:0], m[0], 32'h0),
                '1, {4{32'h8000_0001}}, {4{32'hA5A5_5A5A}});
    // R3 illegal size
    apply("R3 illegal", mkInstr(1, 1, 2'd3, 1, 32'h0), '1, '1, {4{32'hDEAD_BEEF}});
    // R10 ignored fields
    iwA = mkInstr(1, 0, 2'd1, 0, 32'h0);
    apply("R10 base", iwA, {4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, {4{32'h0F0F_0F0F}});
    held = newDest;
    apply("R10 junk fields", mkInstr(1, 0, 2'd1, 0, ~32'h0), {4{32'h1234_5678}},
          {4{32'h9ABC_DEF0}}, {4{32'h0F0F_0F0F}});
    check("R10 same result", newDest, held);
    // R9 idle holds
    held = newDest; heldFlag = undefFlag;
    @(negedge clk);
    inValid = 1'b0; instrWord = 32'h00C0_0000; opA = '1; opB = '1; oldDest = '1;
    @(posedge clk); #1;
    check("R9 outValid low", 128'(outValid), 128'd0);
    check("R9 dest held", newDest, held);
    check("R9 flag held", 128'(undefFlag), 128'(heldFlag));
    // random
    for (int i = 0; i < 400; i++)
      apply("R4 R5 R6 random",
            mkInstr(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), $urandom),
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom});
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule